// File: doc/BRIEF.md
# ADC Resolution Selector and Oversampling Averager

This block sits after a 10-bit converter core and forms the final conversion result. A 2-bit resolution field selects the mode. The 8-bit and 10-bit modes pass each sample straight through into a 12-bit data field. The 11-bit and 12-bit modes sum a fixed group of consecutive samples, then shift the sum to produce one result with more bits. The higher-resolution modes therefore return results at a quarter or a sixteenth of the sample rate.

Samples enter on a valid/ready stream. A transfer happens on a rising clock edge when `in_valid` and `in_ready` are both high. Results leave on a second valid/ready stream. Once a result is presented, `out_valid` and `out_data` stay unchanged until `out_ready` accepts them. While a result is held and `out_ready` is low, `in_ready` drops, so no further sample is taken. When `out_ready` stays high, each result appears as a one-cycle pulse on `out_valid`. The `restart` pin is plain control. A change of the resolution field also resets the group, and any partial sum is lost.

Top module: `adc_res_avg`

## Requirements
- R1: With `res` = 0, each accepted sample gives a result equal to its 8 upper bits (sample >> 2), and `out_data[11:8]` is zero.
- R2: With `res` = 1, each accepted sample gives a result equal to the sample, zero-extended to 12 bits.
- R3: With `res` = 2, four accepted samples give one result equal to their sum shifted right by 1. No result appears after the first three samples of a group.
- R4: With `res` = 3, sixteen accepted samples give one result equal to their sum shifted right by 2. No result appears before the sixteenth sample.
- R5: `out_valid` rises in the cycle after the final sample of a group is accepted. When the result is accepted and no new group finishes, `out_valid` falls in the following cycle.
- R6: In a cycle where `restart` is high, `in_ready` is low. Any partially collected group is discarded, so the next result uses only samples accepted afterwards.
- R7: In the cycle where `res` differs from its value in the previous cycle, `in_ready` is low. The partial group is discarded.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values and `in_ready` is low.
- R9: During and right after reset, `out_valid` is low and no partial group is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| res | input | 2 | Resolution: 0=8b, 1=10b, 2=11b (4 samples), 3=12b (16 samples) |
| restart | input | 1 | Discard the current partial group |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample can be accepted |
| in_data | input | 10 | Converter sample |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result accepted by the consumer |
| out_data | output | 12 | Formatted result |

## Verification
A wrong sample count or a stale accumulator shows up at the ports within one group. In that case the result pulse either comes one accepted sample early or late, or carries a sum that is off by the values left over. Either fault is visible within 4 or 16 accepted samples, depending on the mode. A failure to clear on restart or on a mode change shows in the first result after that event. A broken hold or ready path shows in the same cycle, as a changed `out_data` or a high `in_ready` while output back-pressure is applied. The reference model is compared against `in_ready`, `out_valid` and `out_data` on every clock, so such faults are caught in the cycle where they first appear.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;
  typedef enum logic [1:0] {
    RES_8B  = 2'd0,
    RES_10B = 2'd1,
    RES_11B = 2'd2,
    RES_12B = 2'd3
  } res_e;

  // Samples per result for a resolution setting
  function automatic int unsigned group_len(res_e r);
    case (r)
      RES_11B: group_len = 4;
      RES_12B: group_len = 16;
      default: group_len = 1;
    endcase
  endfunction
endpackage

// File: rtl/avg_accum.sv
module avg_accum
  import adc_avg_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int GRP_MAX = 16,
  localparam int CNT_W = $clog2(GRP_MAX),
  localparam int ACC_W = SAMP_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  res_e              mode,
  input  logic [SAMP_W-1:0] sample,
  output logic              last,
  output logic [ACC_W-1:0]  sum_next
);
  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] final_idx;

  assign final_idx = CNT_W'(group_len(mode) - 1);
  assign sum_next  = acc_q + ACC_W'(sample);
  assign last      = take && (cnt_q == final_idx);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      if (last) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= sum_next;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3 / R4: the count never passes the group size of the current mode
  p_cnt_in_group_r3: assert property (@(posedge clk) disable iff (rst)
    !clr |-> (32'(cnt_q) < group_len(mode)));

  // R9: nothing is left over after reset
  p_clear_after_reset_r9: assert property (@(posedge clk)
    rst |=> (cnt_q == '0) && (acc_q == '0));
endmodule

// File: rtl/avg_scale.sv
module avg_scale
  import adc_avg_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int ACC_W = 14,
  localparam int OUT_W = SAMP_W + 2,
  localparam int LOW_W = SAMP_W - 2
) (
  input  res_e             mode,
  input  logic [ACC_W-1:0] sum,
  output logic [OUT_W-1:0] data
);
  always_comb begin
    case (mode)
      RES_8B:  data = OUT_W'(sum[SAMP_W-1 -: LOW_W]);
      RES_10B: data = OUT_W'(sum[SAMP_W-1:0]);
      RES_11B: data = OUT_W'(sum[SAMP_W+1:1]);
      default: data = sum[SAMP_W+3:2];
    endcase
  end
endmodule

// File: rtl/adc_res_avg.sv
module adc_res_avg
  import adc_avg_pkg::*;
#(
  parameter int SAMP_W = 10,
  localparam int OUT_W = SAMP_W + 2,
  localparam int GRP_MAX = 16,
  localparam int ACC_W = SAMP_W + $clog2(GRP_MAX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        res,
  input  logic              restart,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SAMP_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data
);
  res_e             mode, mode_q;
  logic             mode_chg, clr, take, last;
  logic [ACC_W-1:0] sum_next;
  logic [OUT_W-1:0] scaled;

  assign mode     = res_e'(res);
  assign mode_chg = (mode != mode_q);
  assign clr      = restart || mode_chg;
  assign in_ready = !rst && !clr && (!out_valid || out_ready);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= RES_8B;
    else     mode_q <= mode;
  end

  avg_accum #(.SAMP_W(SAMP_W), .GRP_MAX(GRP_MAX)) u_accum (
    .clk(clk), .rst(rst), .clr(clr), .take(take), .mode(mode),
    .sample(in_data), .last(last), .sum_next(sum_next)
  );

  avg_scale #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_scale (
    .mode(mode), .sum(sum_next), .data(scaled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take && last) begin
      out_valid <= 1'b1;
      out_data  <= scaled;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5: a new result only follows a completed group
  p_result_after_group_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(take && last));
  // R8: held result under back-pressure
  p_hold_under_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_no_take_when_stalled_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
  // R6: restart blocks intake
  p_restart_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    restart |-> !in_ready);
  // R7: mode change blocks intake
  p_mode_change_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (res != $past(res))) |-> !in_ready);
  // R9: reset leaves no result pending
  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/adc_res_avg_tb.sv
module adc_res_avg_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] res = 2'd0;
  logic       restart = 1'b0;
  logic       in_valid = 1'b0;
  logic [9:0] in_data = '0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid;
  logic [11:0] out_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  adc_res_avg u_dut (
    .clk(clk), .rst(rst), .res(res), .restart(restart),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // ---------------- reference model ----------------
  int q[$];
  int m_last_res = 0;
  bit m_valid = 0;
  int m_data = 0;

  function automatic int grp(int r);
    return (r == 2) ? 4 : (r == 3) ? 16 : 1;
  endfunction

  function automatic bit m_ready();
    return !rst && !restart && (int'(res) == m_last_res) && (!m_valid || out_ready);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_last_res = 0; m_valid = 0; m_data = 0;
    end else begin
      bit acc;
      acc = m_ready() && in_valid;
      if (m_valid && out_ready) m_valid = 0;
      if (restart || int'(res) != m_last_res) q.delete();
      else if (acc) begin
        q.push_back(int'(in_data));
        if (q.size() == grp(int'(res))) begin
          int s;
          s = 0;
          foreach (q[i]) s += q[i];
          case (int'(res))
            0: m_data = s >> 2;
            1: m_data = s;
            2: m_data = s >> 1;
            default: m_data = s >> 2;
          endcase
          m_valid = 1;
          q.delete();
        end
      end
      m_last_res = int'(res);
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string data_tag(int r);
    return (r == 0) ? "R1 data" : (r == 1) ? "R2 data" : (r == 2) ? "R3 data" : "R4 data";
  endfunction

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      check("R8/R6/R7 in_ready", int'(in_ready), int'(m_ready()));
      check("R5 out_valid", int'(out_valid), int'(m_valid));
      if (m_valid) check(data_tag(m_last_res), int'(out_data), m_data);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(int v);
    in_valid = 1'b1;
    in_data  = 10'(v);
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_result(string req, int v);
    #1;
    check(req, int'(out_valid), 1);
    check(req, int'(out_data), v);
    @(negedge clk);
  endtask

  task automatic set_res(int r);
    res = 2'(r);
    #1;
    check("R7 ready low on change", int'(in_ready), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    #1;
    check("R9 out_valid in reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check("R9 out_valid after reset", int'(out_valid), 0);
    check("R9 ready after reset", int'(in_ready), 1);
    @(negedge clk);

    // R1: 8-bit mode
    send(10'h3FF); expect_result("R1 max", 12'h0FF);
    send(10'h155); expect_result("R1 pattern", 12'h055);

    // R2: 10-bit mode
    set_res(1);
    send(10'h2AB); expect_result("R2 pattern", 12'h2AB);
    send(10'h3FF); expect_result("R2 max", 12'h3FF);

    // R3: 11-bit mode
    set_res(2);
    send(100); send(200); send(300);
    #1; check("R3 no early result", int'(out_valid), 0);
    send(401); expect_result("R3 sum", 1001 >> 1);
    for (int i = 0; i < 4; i++) send(1023);
    expect_result("R3 max", 2046);

    // R4: 12-bit mode
    set_res(3);
    s = 0;
    for (int i = 0; i < 16; i++) begin
      send(i * 61 + 3);
      s += i * 61 + 3;
      if (i == 14) begin #1; check("R4 no early result", int'(out_valid), 0); end
    end
    expect_result("R4 sum", s >> 2);
    for (int i = 0; i < 16; i++) send(1023);
    expect_result("R4 max", 4092);

    // R6: restart drops partial group
    set_res(2);
    send(900); send(900);
    restart = 1'b1;
    #1; check("R6 ready low on restart", int'(in_ready), 0);
    @(negedge clk);
    restart = 1'b0;
    for (int i = 0; i < 4; i++) send(10);
    expect_result("R6 fresh group", 20);

    // R7: mode change drops partial group
    set_res(3);
    for (int i = 0; i < 5; i++) send(700);
    set_res(2);
    for (int i = 0; i < 4; i++) send(8);
    expect_result("R7 fresh group", 16);

    // R8: back-pressure on output
    set_res(1);
    out_ready = 1'b0;
    send(7);
    for (int i = 0; i < 4; i++) begin
      #1;
      check("R8 held valid", int'(out_valid), 1);
      check("R8 held data", int'(out_data), 7);
      check("R8 ready low", int'(in_ready), 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    #1;
    check("R5 valid falls after accept", int'(out_valid), 0);
    @(negedge clk);

    // R5: back-to-back single-cycle pulses in 8-bit mode
    set_res(0);
    send(40);
    #1; check("R5 pulse", int'(out_valid), 1);
    @(negedge clk);
    #1; check("R5 pulse ends", int'(out_valid), 0);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule